// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block keeps a free-running 64-bit count of nanoseconds for a packet-timing clock. On every counting tick it adds a fixed-point period made of a 16-bit whole-nanosecond part and a 32-bit fraction of a nanosecond. A 32-bit fractional remainder is kept between ticks, so an average rate that is not a whole number, such as 1.6667 ns per cycle for a 600 MHz core clock, is followed exactly over time. Software trims the rate by writing a new period into staging registers. The new period applies only when a separate command is issued.

Software sets the time by writing two 32-bit start words and issuing a load command. It reads the running count through a high word and a low word on a simple register port. A software driver can read the high word, then the low word, then the high word again, and retry if the high word has changed. Counting can be gated by a hardware run input, by a software enable bit, and by a programmable tick-interval prescaler.

Top module: `tod_counter`

## Requirements
- R1: After reset, time_o is 0, rd_data_o is 0, the software enable is off, the tick interval reads 1, and the active and staged period both equal the nominal value (10^9·2^32)/CLK_HZ. The default is 0x1_AAAAAAAA, so the whole part reads 1 and the fraction reads 0xAAAAAAAA.
- R2: On each counting tick, the time grows by the active whole-nanosecond part plus the carry out of the 32-bit sum of the kept remainder and the active fraction. The remainder keeps the low 32 bits of that sum.
- R3: The time stays unchanged unless both run_en_i and the enable bit (control word, address 0, bit 0) are 1.
- R4: The tick interval N sits in control word bits 15:8. While counting is enabled, one tick occurs every N cycles, and N = 0 acts as N = 1.
- R5: Writes to the whole part (address 1) or the fraction (address 2) do not change the rate. Only writing bit 0 of the command word (address 5) copies the staged period one edge after that write. The tick on that same edge still uses the old period.
- R6: Writing bit 1 of the command word loads {start-high (address 3), start-low (address 4)} into the time one edge after that write and clears the remainder. This load overrides a tick on the same edge.
- R7: A period-apply command whose staged period is all zero is ignored, so the rate stays positive.
- R8: Reads return data on rd_data_o one cycle after rd_en_i. The control, period and start registers read back as written, and the command word always reads 0.
- R9: Address 6 returns the upper 32 bits of time_o and address 7 returns the lower 32 bits, as the count stood in the cycle of the read request.
- R10: The whole-nanosecond period field is 16 bits wide. Write bits above it are dropped, and it reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Hardware run gate |
| addr_i | input | 3 | Register word address for reads and writes |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Registered read data, valid one cycle after rd_en_i |
| time_o | output | 64 | Current nanosecond count |

## Verification
The bench builds the block with its default parameters: a 64-bit time, a 16-bit whole part, a 32-bit fraction, an 8-bit tick interval and a nominal 600 MHz period. With these values the fractional carry occurs about two ticks in three. Start values just below 2^32 and 2^64 then reach the carry into the high word and the wrap of the whole count within a few cycles. Tick intervals of 4 and 0 exercise the prescaler. A zero staged period tests the guard against a stopped clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL    = 3'd0,
    A_ADD_INT = 3'd1,
    A_ADD_FRC = 3'd2,
    A_INIT_HI = 3'd3,
    A_INIT_LO = 3'd4,
    A_CMD     = 3'd5,
    A_TIME_HI = 3'd6,
    A_TIME_LO = 3'd7
  } reg_addr_e;

  localparam int CMD_SET_BIT  = 0;
  localparam int CMD_INIT_BIT = 1;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IV_LSB  = 8;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 32,
  parameter int TIME_W = 64,
  parameter int IVAL_W = 8,
  parameter logic [INT_W-1:0]  RST_INT  = '0,
  parameter logic [FRAC_W-1:0] RST_FRAC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_AW-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [TIME_W-1:0]   time_i,
  output logic                ctrl_en,
  output logic [IVAL_W-1:0]   ival,
  output logic [INT_W-1:0]    stg_int,
  output logic [FRAC_W-1:0]   stg_frac,
  output logic [TIME_W-1:0]   init_val,
  output logic                set_pulse,
  output logic                init_pulse,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] init_hi, init_lo;
  logic [DATA_W-1:0] ctrl_word;

  assign init_val = {init_hi, init_lo};

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT] = ctrl_en;
    ctrl_word[CTRL_IV_LSB +: IVAL_W] = ival;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ival       <= IVAL_W'(1);
      stg_int    <= RST_INT;
      stg_frac   <= RST_FRAC;
      init_hi    <= '0;
      init_lo    <= '0;
      set_pulse  <= 1'b0;
      init_pulse <= 1'b0;
    end else begin
      set_pulse  <= 1'b0;
      init_pulse <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            ctrl_en <= wr_data[CTRL_EN_BIT];
            ival    <= wr_data[CTRL_IV_LSB +: IVAL_W];
          end
          A_ADD_INT: stg_int  <= wr_data[INT_W-1:0];
          A_ADD_FRC: stg_frac <= wr_data[FRAC_W-1:0];
          A_INIT_HI: init_hi  <= wr_data[HALF_W-1:0];
          A_INIT_LO: init_lo  <= wr_data[HALF_W-1:0];
          A_CMD: begin
            set_pulse  <= wr_data[CMD_SET_BIT];
            init_pulse <= wr_data[CMD_INIT_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTRL:    rd_data <= ctrl_word;
        A_ADD_INT: rd_data <= DATA_W'(stg_int);
        A_ADD_FRC: rd_data <= DATA_W'(stg_frac);
        A_INIT_HI: rd_data <= DATA_W'(init_hi);
        A_INIT_LO: rd_data <= DATA_W'(init_lo);
        A_TIME_HI: rd_data <= DATA_W'(time_i[TIME_W-1:HALF_W]);
        A_TIME_LO: rd_data <= DATA_W'(time_i[HALF_W-1:0]);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int IVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [IVAL_W-1:0] ival,
  output logic              tick
);
  logic [IVAL_W-1:0] cnt;
  logic [IVAL_W-1:0] lim;

  always_comb begin
    lim  = (ival == '0) ? '0 : ival - IVAL_W'(1);
    tick = run && (cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + IVAL_W'(1);
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int TIME_W = 64,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 32,
  parameter logic [INT_W-1:0]  RST_INT  = '0,
  parameter logic [FRAC_W-1:0] RST_FRAC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              set_pulse,
  input  logic              init_pulse,
  input  logic [INT_W-1:0]  stg_int,
  input  logic [FRAC_W-1:0] stg_frac,
  input  logic [TIME_W-1:0] init_val,
  output logic [TIME_W-1:0] time_o,
  output logic [INT_W-1:0]  act_int
);
  logic [FRAC_W-1:0] act_frac;
  logic [FRAC_W-1:0] rem;
  logic [FRAC_W:0]   fsum;
  logic [TIME_W-1:0] ns_next;
  logic              stg_nonzero;

  always_comb begin
    fsum        = {1'b0, rem} + {1'b0, act_frac};
    ns_next     = time_o + TIME_W'(act_int) + TIME_W'(fsum[FRAC_W]);
    stg_nonzero = (stg_int != '0) || (stg_frac != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_int  <= RST_INT;
      act_frac <= RST_FRAC;
    end else if (set_pulse && stg_nonzero) begin
      act_int  <= stg_int;
      act_frac <= stg_frac;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_o <= '0;
      rem    <= '0;
    end else if (init_pulse) begin
      time_o <= init_val;
      rem    <= '0;
    end else if (tick) begin
      time_o <= ns_next;
      rem    <= fsum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int CLK_HZ = 600_000_000,
  parameter int DATA_W = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 32,
  parameter int TIME_W = 64,
  parameter int IVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TIME_W-1:0] time_o
);
  localparam logic [63:0] NOM = (64'd1_000_000_000 << FRAC_W) / 64'(CLK_HZ);
  localparam logic [INT_W-1:0]  NOM_INT  = NOM[FRAC_W +: INT_W];
  localparam logic [FRAC_W-1:0] NOM_FRAC = NOM[FRAC_W-1:0];

  logic              ctrl_en;
  logic [IVAL_W-1:0] ival;
  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_frac;
  logic [TIME_W-1:0] init_val;
  logic              set_pulse;
  logic              init_pulse;
  logic              tick;
  logic [INT_W-1:0]  act_int;

  tod_regs #(
    .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W),
    .IVAL_W(IVAL_W), .RST_INT(NOM_INT), .RST_FRAC(NOM_FRAC)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(addr_i), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .rd_en(rd_en_i), .time_i(time_o), .ctrl_en(ctrl_en), .ival(ival),
    .stg_int(stg_int), .stg_frac(stg_frac), .init_val(init_val),
    .set_pulse(set_pulse), .init_pulse(init_pulse), .rd_data(rd_data_o)
  );

  tod_prescaler #(.IVAL_W(IVAL_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_en_i && ctrl_en), .ival(ival), .tick(tick)
  );

  tod_accum #(
    .TIME_W(TIME_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
    .RST_INT(NOM_INT), .RST_FRAC(NOM_FRAC)
  ) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .set_pulse(set_pulse),
    .init_pulse(init_pulse), .stg_int(stg_int), .stg_frac(stg_frac),
    .init_val(init_val), .time_o(time_o), .act_int(act_int)
  );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 16,
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en_i,
  input logic              rd_en_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [TIME_W-1:0] time_o,
  input logic              tick,
  input logic              set_pulse,
  input logic              init_pulse,
  input logic [INT_W-1:0]  act_int,
  input logic [TIME_W-1:0] init_val
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (time_o == '0) && (rd_data_o == '0));

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en_i && !init_pulse) |=> $stable(time_o));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !init_pulse) |=>
      ((time_o - $past(time_o)) == TIME_W'($past(act_int))) ||
      ((time_o - $past(time_o)) == TIME_W'($past(act_int)) + TIME_W'(1)));

  // R6
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> time_o == $past(init_val));

  // R8
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == A_CMD) |=> rd_data_o == '0);

  // R5
  set_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    set_pulse |=> !set_pulse);

  // R6
  init_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    init_pulse |=> !init_pulse);
endmodule

bind tod_counter tod_counter_chk #(
  .DATA_W(DATA_W), .INT_W(INT_W), .TIME_W(TIME_W)
) u_chk (
  .clk(clk), .rst(rst), .run_en_i(run_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .rd_data_o(rd_data_o), .time_o(time_o), .tick(tick),
  .set_pulse(set_pulse), .init_pulse(init_pulse), .act_int(act_int),
  .init_val(init_val)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [63:0] time_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string phase = "R1";

  tod_counter u_dut (
    .clk(clk), .rst(rst), .run_en_i(run_en_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .time_o(time_o)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [63:0] m_time;
  logic [31:0] m_frac;
  logic [47:0] m_add, m_stg;
  logic [31:0] m_ihi, m_ilo;
  logic        m_en;
  logic [7:0]  m_iv;
  int          m_cnt;
  logic        m_pset, m_pinit;
  logic [31:0] m_rd;
  logic        m_rdv;
  logic [2:0]  m_rda;
  logic [95:0] acc;

  always @(posedge clk) begin
    if (rst) begin
      m_time = '0; m_frac = '0; m_add = 48'h1_AAAA_AAAA; m_stg = 48'h1_AAAA_AAAA;
      m_ihi = '0; m_ilo = '0; m_en = 1'b0; m_iv = 8'd1; m_cnt = 0;
      m_pset = 1'b0; m_pinit = 1'b0; m_rdv = 1'b0;
    end else begin
      int  per;
      bit  tk;
      per = (m_iv == 0) ? 1 : int'(m_iv);
      tk  = run_en_i && m_en && (m_cnt + 1 >= per);
      m_rdv = rd_en_i;
      m_rda = addr_i;
      if (rd_en_i) begin
        case (addr_i)
          3'd0: m_rd = {16'h0, m_iv, 7'h0, m_en};
          3'd1: m_rd = {16'h0, m_stg[47:32]};
          3'd2: m_rd = m_stg[31:0];
          3'd3: m_rd = m_ihi;
          4:    m_rd = m_ilo;
          6:    m_rd = m_time[63:32];
          7:    m_rd = m_time[31:0];
          default: m_rd = '0;
        endcase
      end
      if (m_pinit) begin
        m_time = {m_ihi, m_ilo}; m_frac = '0;
      end else if (tk) begin
        acc = {m_time, m_frac} + {48'h0, m_add};
        m_time = acc[95:32]; m_frac = acc[31:0];
      end
      if (m_pset && m_stg != 0) m_add = m_stg;
      if (!(run_en_i && m_en) || tk) m_cnt = 0; else m_cnt = m_cnt + 1;
      m_pset = 1'b0; m_pinit = 1'b0;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: begin m_en = wr_data_i[0]; m_iv = wr_data_i[15:8]; end
          3'd1: m_stg[47:32] = wr_data_i[15:0];
          3'd2: m_stg[31:0] = wr_data_i;
          3'd3: m_ihi = wr_data_i;
          3'd4: m_ilo = wr_data_i;
          3'd5: begin m_pset = wr_data_i[0]; m_pinit = wr_data_i[1]; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (time_o !== m_time) begin
        bad++;
        $display("FAIL %s time_o actual=%h expected=%h", phase, time_o, m_time);
      end
      if (m_rdv) begin
        total++;
        if (rd_data_o !== m_rd) begin
          bad++;
          $display("FAIL %s read addr=%0d actual=%h expected=%h",
                   (m_rda >= 6) ? "R9" : "R8", m_rda, rd_data_o, m_rd);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    chk(tag, 64'(rd_data_o), 64'(exp));
  endtask

  task automatic rd_time(input logic [2:0] a);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    idle(4);
    chk("R1 time", time_o, 64'h0);
    chk("R1 rd_data", 64'(rd_data_o), 64'h0);
    rst = 1'b0;
    rd(3'd0, "R1 ctrl", 32'h0000_0100);
    rd(3'd1, "R1 add_int", 32'h1);
    rd(3'd2, "R1 add_frac", 32'hAAAA_AAAA);
    rd(3'd5, "R8 cmd", 32'h0);

    phase = "R3";
    run_en_i = 1'b1;
    idle(8);
    chk("R3 ctrl off", time_o, 64'h0);
    run_en_i = 1'b0;
    wr(3'd0, 32'h0000_0101);
    idle(8);
    chk("R3 run off", time_o, 64'h0);
    rd(3'd0, "R8 ctrl", 32'h0000_0101);

    phase = "R2";
    run_en_i = 1'b1;
    idle(3);
    chk("R2 three ticks", time_o, 64'd4);
    idle(37);
    rd_time(3'd7);
    rd_time(3'd6);

    phase = "R4";
    wr(3'd0, 32'h0000_0401);
    idle(40);
    wr(3'd0, 32'h0000_0001);
    idle(12);

    phase = "R5";
    wr(3'd1, 32'd3);
    wr(3'd2, 32'h8000_0000);
    idle(10);
    rd(3'd1, "R5 staged int", 32'd3);
    rd(3'd2, "R5 staged frac", 32'h8000_0000);
    wr(3'd0, 32'h0000_0101);
    wr(3'd5, 32'h1);
    idle(20);

    phase = "R10";
    wr(3'd1, 32'hFFFF_0002);
    rd(3'd1, "R10 masked int", 32'h0000_0002);

    phase = "R7";
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd5, 32'h1);
    idle(12);

    phase = "R6";
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFF0);
    rd(3'd3, "R8 init hi", 32'hFFFF_FFFF);
    wr(3'd5, 32'h2);
    @(negedge clk);
    chk("R6 load", time_o, 64'hFFFF_FFFF_FFFF_FFF0);
    idle(10);
    rd_time(3'd6);
    rd_time(3'd7);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'hFFFF_FFFE);
    wr(3'd5, 32'h2);
    @(negedge clk);
    chk("R6 load lo", time_o, 64'h0000_0000_FFFF_FFFE);
    idle(3);
    rd_time(3'd6);
    chk("R9 hi carry", 64'(rd_data_o), 64'h1);
    rd(3'd5, "R8 cmd after use", 32'h0);
    idle(4);
    finish_run();
  end
endmodule